// File: doc/BRIEF.md
# Bank-Interleave Read Command Sequencer

This block produces an endless DRAM command stream for operating-current measurement with all four banks interleaved. Each loop visits bank 0, then 1, then 2, then 3. Every bank gets an activate, and on the very next clock a read with autoprecharge that uses a burst length of 4. Deselect cycles go in between the bank pairs and at the end of the loop. They keep the activate-to-activate spacing and the row-cycle time legal for the clock period of the chosen speed bin.

A 3-bit bin select picks one of seven fixed patterns. The patterns differ in the number of deselects between pairs and in the number of deselects after the last pair, so the loop length is 11, 15, 16, 19, 20, 23 or 24 clocks. A one-clock strobe marks the start of each loop. The bank output changes only when a command is issued, so the address lines stay quiet during deselects. Pin-level command encoding is left to the logic downstream.

Top module: `bank_ilv_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs are `cmdOut`=2'b00, `bankOut`=0 and `loopStart`=0. On the first clock after reset is released, the outputs show an activate to bank 0.
- R2: Commands are encoded as 2'b00 deselect, 2'b01 activate and 2'b10 read with autoprecharge. Within a loop, banks 0, 1, 2 and 3 each get an activate, in that order. The clock right after each activate carries a read with autoprecharge to the same bank.
- R3: The number of deselects between the read to one bank and the activate to the next bank is set by `binSel`: 0 → 0, 1 → 1, 2 → 1, 3 → 2, 4 → 2, 5 → 2, 6 → 2.
- R4: The number of deselects after the bank-3 read is set by `binSel`: 0 → 3, 1 → 4, 2 → 5, 3 → 5, 4 → 6, 5 → 9, 6 → 10. This gives loops of 11, 15, 16, 19, 20, 23 and 24 clocks.
- R5: `loopStart` is high for exactly one clock per loop, the clock that carries the bank-0 activate, and is low on all other clocks.
- R6: On a deselect clock, `bankOut` keeps the bank of the most recent command.
- R7: `binSel` is sampled only during reset and on the clock where the last deselect of a loop appears on the outputs. A change partway through a loop leaves the rest of that loop unchanged and takes effect from the next bank-0 activate.
- R8: A `binSel` value of 7 produces the same pattern as 6.
- R9: Asserting `rst` partway through a loop drops the stream to deselect. After release, a complete loop starts again from the bank-0 activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| binSel | input | 3 | Speed-bin pattern select, 0..6 (7 acts as 6) |
| cmdOut | output | 2 | Command for this clock: 00 deselect, 01 activate, 10 read with autoprecharge |
| bankOut | output | 2 | Bank address, held during deselects |
| loopStart | output | 1 | One-clock strobe on the bank-0 activate |

## Verification
The bench runs every bin for two full loops and compares each clock against a model built from the gap and tail counts. A wrong padding entry would make the loop one clock too long or too short. A bank address that drifts on deselects would show up as a bank mismatch on the padding clocks. Changing the select partway through a loop catches a design that picks up the new bin at once and cuts or stretches the current loop. Reset in the middle of a loop, followed by a full loop, catches a counter that keeps its old place. Select value 7 is checked so that an unmapped code cannot fall back to a zero-padding pattern.

// File: rtl/bank_ilv_pkg.sv
`timescale 1ns/1ps
package bank_ilv_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int SEL_W     = 3;
  localparam int MAX_GAP   = 2;
  localparam int MAX_TAIL  = 10;
  localparam int SUB_W     = $clog2(MAX_TAIL + 2);
  localparam int MAX_LOOP  = 2 * NUM_BANKS + (NUM_BANKS - 1) * MAX_GAP + MAX_TAIL;

  typedef enum logic [1:0] {
    CMD_DES = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RDA = 2'b10
  } cmd_e;

  typedef struct packed {
    logic              act;
    logic              rd;
    logic              loop;
    logic [BANK_W-1:0] bank;
  } seq_strobe_t;

  // deselects between consecutive bank pairs
  function automatic logic [SUB_W-1:0] binGap(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:       return SUB_W'(0);
      3'd1, 3'd2: return SUB_W'(1);
      default:    return SUB_W'(2);
    endcase
  endfunction

  // deselects after the final bank pair
  function automatic logic [SUB_W-1:0] binTail(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:       return SUB_W'(3);
      3'd1:       return SUB_W'(4);
      3'd2, 3'd3: return SUB_W'(5);
      3'd4:       return SUB_W'(6);
      3'd5:       return SUB_W'(9);
      default:    return SUB_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/bank_ilv_ctrl.sv
`timescale 1ns/1ps
module bank_ilv_ctrl
  import bank_ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] binSel,
  output seq_strobe_t      stb
);
  logic [BANK_W-1:0] bankCnt;
  logic [SUB_W-1:0]  subCnt;
  logic [SUB_W-1:0]  gapR;
  logic [SUB_W-1:0]  tailR;
  logic [SUB_W-1:0]  segEnd;
  logic              lastBank;
  logic              segDone;

  assign lastBank = (bankCnt == BANK_W'(NUM_BANKS - 1));
  assign segEnd   = lastBank ? (SUB_W'(1) + tailR) : (SUB_W'(1) + gapR);
  assign segDone  = (subCnt == segEnd);

  always_ff @(posedge clk) begin
    if (rst) begin
      bankCnt <= '0;
      subCnt  <= '0;
      gapR    <= binGap(binSel);
      tailR   <= binTail(binSel);
    end else if (segDone) begin
      subCnt <= '0;
      if (lastBank) begin
        bankCnt <= '0;
        gapR    <= binGap(binSel);
        tailR   <= binTail(binSel);
      end else begin
        bankCnt <= bankCnt + BANK_W'(1);
      end
    end else begin
      subCnt <= subCnt + SUB_W'(1);
    end
  end

  always_comb begin
    stb.act  = (subCnt == SUB_W'(0));
    stb.rd   = (subCnt == SUB_W'(1));
    stb.loop = (subCnt == SUB_W'(0)) && (bankCnt == '0);
    stb.bank = bankCnt;
  end
endmodule

// File: rtl/bank_ilv_dp.sv
`timescale 1ns/1ps
module bank_ilv_dp
  import bank_ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_strobe_t       stb,
  output logic [1:0]        cmdOut,
  output logic [BANK_W-1:0] bankOut,
  output logic              loopStart
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdOut    <= CMD_DES;
      bankOut   <= '0;
      loopStart <= 1'b0;
    end else begin
      if (stb.act)     cmdOut <= CMD_ACT;
      else if (stb.rd) cmdOut <= CMD_RDA;
      else             cmdOut <= CMD_DES;
      if (stb.act || stb.rd) bankOut <= stb.bank;
      loopStart <= stb.loop;
    end
  end
endmodule

// File: rtl/bank_ilv_seq.sv
`timescale 1ns/1ps
module bank_ilv_seq
  import bank_ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] binSel,
  output logic [1:0]       cmdOut,
  output logic [BANK_W-1:0] bankOut,
  output logic             loopStart
);
  seq_strobe_t stb;

  bank_ilv_ctrl ctrlI (
    .clk    (clk),
    .rst    (rst),
    .binSel (binSel),
    .stb    (stb)
  );

  bank_ilv_dp dpI (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .cmdOut    (cmdOut),
    .bankOut   (bankOut),
    .loopStart (loopStart)
  );
endmodule

// File: rtl/bank_ilv_chk.sv
`timescale 1ns/1ps
module bank_ilv_chk
  import bank_ilv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cmdOut,
  input logic [BANK_W-1:0] bankOut,
  input logic              loopStart
);
  localparam int CNT_W = $clog2(MAX_LOOP + 1);
  logic [CNT_W-1:0] sinceLoop;

  always_ff @(posedge clk) begin
    if (rst)                          sinceLoop <= '0;
    else if (loopStart)               sinceLoop <= CNT_W'(1);
    else if (sinceLoop != CNT_W'(MAX_LOOP)) sinceLoop <= sinceLoop + CNT_W'(1);
  end

  a_r1_reset_des: assert property (@(posedge clk)
    rst |=> (cmdOut == CMD_DES && !loopStart));

  a_r2_act_then_rd: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == CMD_ACT) |=> (cmdOut == CMD_RDA && bankOut == $past(bankOut)));

  a_r2_rd_after_act: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == CMD_RDA) |-> ($past(cmdOut) == CMD_ACT));

  a_r5_strobe_on_act0: assert property (@(posedge clk) disable iff (rst)
    loopStart |-> (cmdOut == CMD_ACT && bankOut == '0));

  a_r5_act0_has_strobe: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == CMD_ACT && bankOut == '0) |-> loopStart);

  a_r6_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (cmdOut == CMD_DES && !$past(rst)) |-> $stable(bankOut));

  a_r4_loop_bound: assert property (@(posedge clk) disable iff (rst)
    !loopStart |-> (sinceLoop < CNT_W'(MAX_LOOP)));
endmodule

bind bank_ilv_seq bank_ilv_chk chkI (
  .clk       (clk),
  .rst       (rst),
  .cmdOut    (cmdOut),
  .bankOut   (bankOut),
  .loopStart (loopStart)
);

// File: tb/tb_bank_ilv_seq.sv
`timescale 1ns/1ps
module tb_bank_ilv_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] binSel = 3'd0;
  logic [1:0] cmdOut;
  logic [1:0] bankOut;
  logic       loopStart;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bank_ilv_seq dut (
    .clk(clk), .rst(rst), .binSel(binSel),
    .cmdOut(cmdOut), .bankOut(bankOut), .loopStart(loopStart)
  );

  function automatic int gapOf(input int b);
    case (b) 0: return 0; 1, 2: return 1; default: return 2; endcase
  endfunction
  function automatic int tailOf(input int b);
    case (b) 0: return 3; 1: return 4; 2, 3: return 5; 4: return 6; 5: return 9; default: return 10; endcase
  endfunction
  function automatic int lenOf(input int b);
    return 3 * (2 + gapOf(b)) + 2 + tailOf(b);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // check clocks fromPos..toPos of a loop of bin b; each clock sampled on the falling edge
  task automatic runCycles(input int b, input int fromPos, input int toPos, input string force_req);
    for (int pos = fromPos; pos <= toPos; pos++) begin
      int seg = 2 + gapOf(b);
      int bk, off, ec;
      string rc, rb;
      if (pos < 3 * seg) begin bk = pos / seg; off = pos % seg; end
      else begin bk = 3; off = pos - 3 * seg; end
      ec = (off == 0) ? 1 : (off == 1) ? 2 : 0;
      rc = (ec != 0) ? "R2" : ((bk == 3) ? "R4" : "R3");
      rb = (ec != 0) ? "R2" : "R6";
      if (force_req != "") begin rc = force_req; rb = force_req; end
      @(posedge clk); @(negedge clk);
      chk(rc, $sformatf("bin%0d pos%0d cmd", b, pos), cmdOut, ec);
      chk(rb, $sformatf("bin%0d pos%0d bank", b, pos), bankOut, bk);
      chk((force_req != "") ? force_req : "R5", $sformatf("bin%0d pos%0d loopStart", b, pos),
          loopStart, (pos == 0) ? 1 : 0);
    end
  endtask

  task automatic doReset(input logic [2:0] sel);
    @(negedge clk);
    rst = 1'b1; binSel = sel;
    repeat (3) @(negedge clk);
    chk("R1", "reset cmd", cmdOut, 0);
    chk("R1", "reset bank", bankOut, 0);
    chk("R1", "reset loopStart", loopStart, 0);
    rst = 1'b0;
  endtask

  task automatic testAllBins();
    for (int b = 0; b < 7; b++) begin
      doReset(3'(b));
      runCycles(b, 0, lenOf(b) - 1, "");
      runCycles(b, 0, lenOf(b) - 1, "");
      @(posedge clk); @(negedge clk);
      chk("R4", $sformatf("bin%0d loop length %0d", b, lenOf(b)), loopStart, 1);
    end
  endtask

  task automatic testMidChange();
    doReset(3'd5);
    runCycles(5, 0, 4, "");
    binSel = 3'd0;
    runCycles(5, 5, lenOf(5) - 1, "R7");
    runCycles(0, 0, lenOf(0) - 1, "R7");
    runCycles(0, 0, lenOf(0) - 1, "R7");
  endtask

  task automatic testSel7();
    doReset(3'd7);
    runCycles(6, 0, lenOf(6) - 1, "R8");
    runCycles(6, 0, lenOf(6) - 1, "R8");
  endtask

  task automatic testResetMidLoop();
    doReset(3'd3);
    runCycles(3, 0, 7, "");
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9", "cmd during mid-loop reset", cmdOut, 0);
    chk("R9", "loopStart during mid-loop reset", loopStart, 0);
    rst = 1'b0;
    runCycles(3, 0, lenOf(3) - 1, "R9");
    runCycles(3, 0, 0, "R9");
  endtask

  initial begin
    testAllBins();
    testMidChange();
    testSel7();
    testResetMidLoop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule